// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a watchdog counter on a simple 32-bit register bus. Once enabled, it counts clock ticks from zero. Software programs two thresholds against the single counter:

- **Early-warning threshold.** Reaching it can raise a level interrupt, provided the interrupt is allowed.
- **Final threshold.** Reaching it issues a fixed-length reset request to the system.

Software keeps the timer from expiring by writing the restart register, which zeroes the counter. Clearing the enable register stops the timer.

A sticky flag records that a reset request was issued. The flag sits on its own power-on reset, so the system reset that the request causes does not clear it. After boot, software reads the flag to learn why the chip restarted, and clears it by writing one to it.

Register map. Byte offsets are on a word-aligned bus. Unmapped offsets read zero and ignore writes.

| Offset | Register | Use |
|---|---|---|
| 0x04 | kick | write bit 0 = 1 to restart the count; reads 0 |
| 0x08 | control | bit 0 = run, bit 1 = warning interrupt allow; other bits read 0 |
| 0x0C | cause | bit 0 = sticky expiry flag; write 1 to clear |
| 0x10 | warn_lim | warning threshold in ticks |
| 0x14 | expire_lim | expiry threshold in ticks |

Top module: `wdog_bark_bite`

## Requirements
- R1: After `rst_ni` and `por_ni`, every register reads 0 and both `warn_irq_o` and `sys_rst_req_o` are low.
- R2: The control register reads back bits [1:0] as written, with all other bits reading 0. Both threshold registers read back full 32-bit values, and 0x1000_0000 is a legal threshold. The kick register reads 0.
- R3: Any write to the control register that sets run zeroes the counter on that clock edge. The counter then rises by one per cycle and saturates at all-ones instead of wrapping. `sys_rst_req_o` rises exactly `expire_lim`+1 cycles after that edge.
- R4: With both control bits set, `warn_irq_o` rises exactly `warn_lim`+1 cycles after the enabling edge. It then stays high until a kick or a control write.
- R5: `warn_irq_o` stays low while control bit 1 is 0, even after the count passes `warn_lim`.
- R6: A write of 1 to bit 0 of the kick register zeroes the counter and drops `warn_irq_o` on that edge. Both thresholds are then measured from that edge. A kick write with bit 0 = 0 has no effect.
- R7: Writing 0 to the control register drops `warn_irq_o` at once. While the timer is disabled, no warning and no reset request occur.
- R8: A reset request is high for exactly `RST_PULSE` cycles, and then the counter halts. No further request occurs until the control register is written again.
- R9: The cause flag (bit 0 at 0x0C) is set by each reset request. Neither `rst_ni` nor a write of 0 clears it. Writing 1 to it or asserting `por_ni` clears it.
- R10: When `warn_lim` equals `expire_lim`, the warning and the reset request both assert in the same cycle, `expire_lim`+1 cycles after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and bus clock |
| rst_ni | input | 1 | Active-low async system reset (all state except cause flag) |
| por_ni | input | 1 | Active-low async power-on reset for the cause flag |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| warn_irq_o | output | 1 | Early-warning interrupt level |
| sys_rst_req_o | output | 1 | Reset request pulse |

## Verification
Every register write takes effect on the edge that samples `we_i`, and cycle 0 is counted from that edge. The warning level is due after `warn_lim`+1 edges. The reset request is due after `expire_lim`+1 edges and stays high for `RST_PULSE` edges. Read data is valid in the same cycle as the address.

The bench drives every input on a falling edge and samples on later falling edges. It counts edges after each write and records the first cycle in which each output goes high. It then compares those cycle numbers with the values worked out from the thresholds, so a single cycle of skew is reported. Effects that should be absent, such as a gated warning, a disabled timer or a halted counter, are checked by watching the outputs over a window longer than any programmed threshold.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFF_KICK   = 32'h04;
  localparam int unsigned OFF_CTRL   = 32'h08;
  localparam int unsigned OFF_CAUSE  = 32'h0C;
  localparam int unsigned OFF_WARN   = 32'h10;
  localparam int unsigned OFF_EXPIRE = 32'h14;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned CTRL_W     = 2;

  typedef struct packed {
    logic irq_allow;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              expire_evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  warn_lim_o,
  output logic [CNT_W-1:0]  expire_lim_o,
  output logic              kick_o,
  output logic              rearm_o
);
  logic sel_kick, sel_ctrl, sel_cause, sel_warn, sel_expire;
  logic cause_q, cause_clr;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] warn_q, expire_q;

  assign sel_kick   = addr_i == ADDR_W'(OFF_KICK);
  assign sel_ctrl   = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_cause  = addr_i == ADDR_W'(OFF_CAUSE);
  assign sel_warn   = addr_i == ADDR_W'(OFF_WARN);
  assign sel_expire = addr_i == ADDR_W'(OFF_EXPIRE);

  assign kick_o    = we_i & sel_kick & wdata_i[0];
  assign rearm_o   = we_i & sel_ctrl;
  assign cause_clr = we_i & sel_cause & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      warn_q   <= '0;
      expire_q <= '0;
    end else if (we_i) begin
      if (sel_ctrl)   ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (sel_warn)   warn_q   <= wdata_i[CNT_W-1:0];
      if (sel_expire) expire_q <= wdata_i[CNT_W-1:0];
    end
  end

  // cause flag lives on power-on reset only; set beats clear
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)           cause_q <= 1'b0;
    else if (expire_evt_i) cause_q <= 1'b1;
    else if (cause_clr)    cause_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_ctrl:   rdata_o = BUS_W'(ctrl_q);
      sel_cause:  rdata_o = BUS_W'(cause_q);
      sel_warn:   rdata_o = BUS_W'(warn_q);
      sel_expire: rdata_o = BUS_W'(expire_q);
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign warn_lim_o   = warn_q;
  assign expire_lim_o = expire_q;

  p_cause_sticky_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (cause_q && !cause_clr) |=> cause_q);
  p_cause_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    expire_evt_i |=> cause_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             irq_allow_i,
  input  logic [CNT_W-1:0] warn_lim_i,
  input  logic [CNT_W-1:0] expire_lim_i,
  input  logic             kick_i,
  input  logic             rearm_i,
  output logic             warn_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic halt_q, warn_q, active, clr, at_max;

  assign active = run_i & ~halt_q;
  assign clr    = ~run_i | rearm_i | kick_i;
  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (active && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  // a kick or rearm in the hit cycle wins over expiry
  assign expire_o = active & ~kick_i & ~rearm_i & (cnt_q >= expire_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 halt_q <= 1'b0;
    else if (rearm_i || !run_i)  halt_q <= 1'b0;
    else if (expire_o)           halt_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_q <= 1'b0;
    else warn_q <= run_i & irq_allow_i & ~kick_i & ~rearm_i &
                   (warn_q | (cnt_q >= warn_lim_i));
  end

  assign warn_o = warn_q;

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !clr && !at_max) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !clr && at_max) |=> &cnt_q);
  p_single_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !rearm_i) |=> !expire_o);
  p_warn_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_q && run_i && irq_allow_i && !kick_i && !rearm_i) |=> warn_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (trig_i)         left_q <= PW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = left_q != '0;

  generate
    if (LEN > 1) begin : g_multi
      p_pulse_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |=> pulse_o);
    end else begin : g_single
      p_pulse_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_o && !trig_i) |=> !pulse_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              warn_irq_o,
  output logic              sys_rst_req_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] warn_lim, expire_lim;
  logic kick, rearm, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .por_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .expire_evt_i (expire),
    .ctrl_o       (ctrl),
    .warn_lim_o   (warn_lim),
    .expire_lim_o (expire_lim),
    .kick_o       (kick),
    .rearm_o      (rearm)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .run_i        (ctrl.run),
    .irq_allow_i  (ctrl.irq_allow),
    .warn_lim_i   (warn_lim),
    .expire_lim_i (expire_lim),
    .kick_i       (kick),
    .rearm_i      (rearm),
    .warn_o       (warn_irq_o),
    .expire_o     (expire)
  );

  wdog_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk_i, .rst_ni,
    .trig_i  (expire),
    .pulse_o (sys_rst_req_o)
  );

  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.irq_allow |=> !warn_irq_o);
  p_quiet_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |=> !$rose(sys_rst_req_o));
  p_req_on_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> sys_rst_req_o);
endmodule

// File: tb/wdog_bark_bite_bench.sv
module wdog_bark_bite_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;
  localparam logic [4:0] A_KICK = 5'h04, A_CTRL = 5'h08, A_CAUSE = 5'h0C,
                         A_WARN = 5'h10, A_EXP = 5'h14;

  typedef struct packed {
    logic [31:0] warn;
    logic [31:0] expire;
    logic [31:0] ctrl;
    logic [7:0]  exp_irq;   // 0 = never
    logic [7:0]  exp_req;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'd5,  32'd10, 32'd3, 8'd6,  8'd11},  // R3 R4
    '{32'd5,  32'd10, 32'd1, 8'd0,  8'd11},  // R5
    '{32'd7,  32'd7,  32'd3, 8'd8,  8'd8 },  // R10
    '{32'd0,  32'd3,  32'd3, 8'd1,  8'd4 },  // R4 zero limit
    '{32'd20, 32'd12, 32'd3, 8'd0,  8'd13}   // R8 halt freezes count
  };

  logic clk = 0, rst_ni = 0, por_ni = 0, we = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, req;
  int n_chk = 0, n_fail = 0;
  logic [31:0] v;
  int fi, fr, w, rises;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_bark_bite u_wdog_bark_bite (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .warn_irq_o(irq), .sys_rst_req_o(req)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic meas(input int n, output int first_irq, output int first_req,
                      output int width, output int nrise);
    logic prev = req;
    first_irq = 0; first_req = 0; width = 0; nrise = 0;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (irq && first_irq == 0) first_irq = c;
      if (req) begin
        if (first_req == 0) first_req = c;
        width++;
      end
      if (req && !prev) nrise++;
      prev = req;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1; por_ni = 1;
    // R1 reset state
    chk(irq == 0 && req == 0, "R1", "outputs after reset", {irq, req}, 0);
    rd(A_CTRL, v);  chk(v == 0, "R1", "ctrl", v, 0);
    rd(A_WARN, v);  chk(v == 0, "R1", "warn_lim", v, 0);
    rd(A_EXP, v);   chk(v == 0, "R1", "expire_lim", v, 0);
    rd(A_CAUSE, v); chk(v == 0, "R1", "cause", v, 0);

    // R2 readback
    wr(A_WARN, 32'h1000_0000); rd(A_WARN, v);
    chk(v == 32'h1000_0000, "R2", "warn_lim large", v, 32'h1000_0000);
    wr(A_EXP, 32'hA5A5_5A5A); rd(A_EXP, v);
    chk(v == 32'hA5A5_5A5A, "R2", "expire_lim", v, 32'hA5A5_5A5A);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v);
    chk(v == 32'd2, "R2", "ctrl masked", v, 2);
    rd(A_KICK, v); chk(v == 0, "R2", "kick reads zero", v, 0);
    wr(A_CTRL, 0);

    // table walk: R3 R4 R5 R8 R10
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 0);
      wr(A_WARN, VECS[i].warn);
      wr(A_EXP, VECS[i].expire);
      wr(A_CTRL, VECS[i].ctrl);
      meas(40, fi, fr, w, rises);
      chk(fi == int'(VECS[i].exp_irq), (VECS[i].ctrl[1] ? "R4/R10" : "R5"),
          $sformatf("vec%0d warn cycle", i), fi, VECS[i].exp_irq);
      chk(fr == int'(VECS[i].exp_req), "R3/R10",
          $sformatf("vec%0d req cycle", i), fr, VECS[i].exp_req);
      chk(w == PULSE && rises == 1, "R8",
          $sformatf("vec%0d pulse width", i), w, PULSE);
    end

    // R6 kick restarts both thresholds
    wr(A_CTRL, 0); wr(A_WARN, 3); wr(A_EXP, 10); wr(A_CTRL, 3);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R4", "warn level held", irq, 1);
    wr(A_KICK, 1);
    chk(irq == 0, "R6", "kick drops warn", irq, 0);
    meas(30, fi, fr, w, rises);
    chk(fi == 4, "R6", "warn after kick", fi, 4);
    chk(fr == 11, "R6", "req after kick", fr, 11);

    // R6 kick with bit0 = 0 ignored
    wr(A_CTRL, 0); wr(A_EXP, 8); wr(A_CTRL, 1);
    repeat (2) @(negedge clk);
    wr(A_KICK, 0);
    meas(20, fi, fr, w, rises);
    chk(fr == 5, "R6", "zero kick ignored", fr, 5);

    // R7 disable
    wr(A_CTRL, 0); wr(A_WARN, 2); wr(A_EXP, 6); wr(A_CTRL, 3);
    repeat (3) @(negedge clk);
    chk(irq == 1, "R4", "warn before disable", irq, 1);
    wr(A_CTRL, 0);
    chk(irq == 0, "R7", "disable drops warn", irq, 0);
    meas(30, fi, fr, w, rises);
    chk(fi == 0 && fr == 0, "R7", "quiet while disabled", fi + fr, 0);

    // R8 halt then rearm
    wr(A_EXP, 4); wr(A_CTRL, 1);
    meas(40, fi, fr, w, rises);
    chk(fr == 5 && rises == 1, "R8", "single request then halt", rises, 1);
    wr(A_CTRL, 1);
    meas(20, fi, fr, w, rises);
    chk(fr == 5, "R8", "rearm restarts", fr, 5);

    // R9 cause flag
    rd(A_CAUSE, v); chk(v == 1, "R9", "cause set", v, 1);
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1;
    rd(A_CAUSE, v); chk(v == 1, "R9", "cause survives rst_ni", v, 1);
    rd(A_CTRL, v);  chk(v == 0, "R9", "ctrl cleared by rst_ni", v, 0);
    wr(A_CAUSE, 0); rd(A_CAUSE, v); chk(v == 1, "R9", "write 0 keeps", v, 1);
    wr(A_CAUSE, 1); rd(A_CAUSE, v); chk(v == 0, "R9", "write 1 clears", v, 0);
    wr(A_EXP, 2); wr(A_CTRL, 1);
    meas(10, fi, fr, w, rises);
    rd(A_CAUSE, v); chk(v == 1, "R9", "cause set again", v, 1);
    @(negedge clk); por_ni = 0; @(negedge clk); por_ni = 1;
    rd(A_CAUSE, v); chk(v == 0, "R9", "por clears cause", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule